// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in without a rippling carry chain. Every bit position forms a generate term (both operand bits set) and a propagate term (either operand bit set). A first lookahead level turns these terms into flat sum-of-products carries inside each 4-bit group. It also produces one group generate and one group propagate for each group. A second lookahead unit, the same circuit with the same parameters, takes the group terms and the external carry-in. From them it forms the carry into every group and the carry-out directly. Each sum bit is the XOR of the two operand bits and the carry into that bit. The XOR is a separate signal from the OR-based propagate.

The block also exports its own block-level generate and propagate. A higher lookahead level can use them to combine four of these adders into a 64-bit adder. The group width and the group count are parameters. The default is four groups of four bits. The add itself is combinational. Its results are captured in one output register stage, so the outputs for an operand set appear on the clock edge after those operands are sampled.

Top module: `cla16_adder`

## Requirements
- R1: While `rst_n` is low, the sum, the carry-out, the block generate and the block propagate are all 0.
- R2: One clock edge after inputs are sampled, `{cout_o, sum_o}` equals the 17-bit value `a_i + b_i + cin_i`.
- R3: `blk_p_o` is 1 exactly when every bit position has at least one operand bit set, that is when the AND over all bits of `a_i | b_i` is 1.
- R4: `blk_g_o` is 1 exactly when `a_i + b_i` with a carry-in of 0 produces a carry out of the top bit.
- R5: `cout_o` equals `blk_g_o | (blk_p_o & cin_i)` for the same sampled inputs. Within each group, the group's flat carry-out equals its group generate OR (its group propagate AND its carry-in).
- R6: When every bit propagates and no bit generates (`a_i ^ b_i` all ones, `a_i & b_i` zero), a carry-in of 1 crosses all groups: the sum is 0 and the carry-out is 1.
- R7: A carry generated in the top bit of one group reaches the bottom bit of the next group. The carry into each group from the second level equals the carry-out computed inside the group below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |
| blk_g_o | output | 1 | Registered block generate |
| blk_p_o | output | 1 | Registered block propagate |

## Verification
On every clock, the assertions compare the registered sum and carry against an arithmetic add of the previous inputs. They also check the block propagate against the OR/AND reduction of the operands. Inside each lookahead unit they check that the carry-out agrees with the unit's own generate and propagate. They also check that every carry from the second level matches the carry-out of the group below. The bench's scenarios are needed for the reset values, for every 4-bit pattern at each group position, and for the long-carry cases where the fill around a group forces a carry to cross every group or be stopped at each group boundary.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int unsigned CLA_GRP_W_DEF   = 4;
    localparam int unsigned CLA_NUM_GRP_DEF = 4;
endpackage

// File: rtl/cla_pg_gen.sv
module cla_pg_gen #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] half_o
);
    always_comb begin
        gen_o  = a_i & b_i;
        prop_o = a_i | b_i;
        half_o = a_i ^ b_i;
    end
endmodule

// File: rtl/cla_lookahead.sv
// Flat sum-of-products lookahead over W generate/propagate pairs.
// Serves as the first-level group unit and as the second-level unit.
module cla_lookahead #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         cin_i,
    output logic [W-1:0] carry_o,
    output logic         cout_o,
    output logic         grp_g_o,
    output logic         grp_p_o
);
    logic [W:0] carry_d;
    logic       grp_g_d;
    logic       grp_p_d;

    always_comb begin
        logic acc;
        logic term;
        for (int j = 0; j <= int'(W); j++) begin
            acc = cin_i;
            for (int k = 0; k < j; k++) acc = acc & prop_i[k];
            for (int k = 0; k < j; k++) begin
                term = gen_i[k];
                for (int m = k + 1; m < j; m++) term = term & prop_i[m];
                acc = acc | term;
            end
            carry_d[j] = acc;
        end
        grp_p_d = &prop_i;
        grp_g_d = 1'b0;
        for (int k = 0; k < int'(W); k++) begin
            term = gen_i[k];
            for (int m = k + 1; m < int'(W); m++) term = term & prop_i[m];
            grp_g_d = grp_g_d | term;
        end
        // R5: the flat carry-out agrees with the group terms
        a_r5_group_cout: assert (carry_d[W] == (grp_g_d | (grp_p_d & cin_i)));
    end

    assign carry_o = carry_d[W-1:0];
    assign cout_o  = carry_d[W];
    assign grp_g_o = grp_g_d;
    assign grp_p_o = grp_p_d;
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int unsigned GRP_W   = CLA_GRP_W_DEF,
    parameter int unsigned NUM_GRP = CLA_NUM_GRP_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [GRP_W*NUM_GRP-1:0]   a_i,
    input  logic [GRP_W*NUM_GRP-1:0]   b_i,
    input  logic                       cin_i,
    output logic [GRP_W*NUM_GRP-1:0]   sum_o,
    output logic                       cout_o,
    output logic                       blk_g_o,
    output logic                       blk_p_o
);
    localparam int unsigned WIDTH = GRP_W * NUM_GRP;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic             blk_g;
        logic             blk_p;
    } out_t;

    out_t st_d, st_q;

    logic [WIDTH-1:0]   bit_g, bit_p, bit_x, bit_c;
    logic [NUM_GRP-1:0] grp_g, grp_p, grp_c, grp_cout;
    logic               top_cout, top_g, top_p;

    cla_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (bit_g),
        .prop_o (bit_p),
        .half_o (bit_x)
    );

    for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
        cla_lookahead #(.W(GRP_W)) u_grp (
            .gen_i   (bit_g[k*GRP_W +: GRP_W]),
            .prop_i  (bit_p[k*GRP_W +: GRP_W]),
            .cin_i   (grp_c[k]),
            .carry_o (bit_c[k*GRP_W +: GRP_W]),
            .cout_o  (grp_cout[k]),
            .grp_g_o (grp_g[k]),
            .grp_p_o (grp_p[k])
        );
    end

    cla_lookahead #(.W(NUM_GRP)) u_second (
        .gen_i   (grp_g),
        .prop_i  (grp_p),
        .cin_i   (cin_i),
        .carry_o (grp_c),
        .cout_o  (top_cout),
        .grp_g_o (top_g),
        .grp_p_o (top_p)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sum   = bit_x ^ bit_c;
        st_d.cout  = top_cout;
        st_d.blk_g = top_g;
        st_d.blk_p = top_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o   = st_q.sum;
    assign cout_o  = st_q.cout;
    assign blk_g_o = st_q.blk_g;
    assign blk_p_o = st_q.blk_p;

    // R1: outputs cleared while reset is held
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0 && !cout_o && !blk_g_o && !blk_p_o));

    // R2: registered result equals the arithmetic sum of the previous inputs
    a_r2_sum_match: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({cout_o, sum_o} ==
            ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{WIDTH{1'b0}}, $past(cin_i)})));

    // R3: block propagate is the AND of all bitwise ORs
    a_r3_blk_prop: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (blk_p_o == (&($past(a_i) | $past(b_i)))));

    // R5: carry-out from block terms and carry-in
    a_r5_cout_terms: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cout_o == (blk_g_o | (blk_p_o & $past(cin_i)))));

    // R7: second-level carry into each group matches the group below
    for (genvar k = 0; k + 1 < NUM_GRP; k++) begin : g_chk
        a_r7_group_link: assert property (@(posedge clk) disable iff (!rst_n)
            grp_c[k+1] == grp_cout[k]);
    end
    a_r7_top_link: assert property (@(posedge clk) disable iff (!rst_n)
        top_cout == grp_cout[NUM_GRP-1]);
endmodule

// File: tb/cla16_adder_bench.sv
module cla16_adder_bench;
    localparam int W = 16;
    localparam time TCLK = 8ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout, blk_g, blk_p;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(TCLK/2) clk = ~clk;

    cla16_adder u_cla16_adder (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout), .blk_g_o(blk_g), .blk_p_o(blk_p)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h cin=%0b)", req, got, exp, a, b, cin);
        end
    endtask

    // Drive one vector, wait for the capturing edge, then check away from the edge.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc, input string tag);
        logic [W:0] full;
        logic [W:0] nocin;
        a = va; b = vb; cin = vc;
        full  = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        nocin = {1'b0, va} + {1'b0, vb};
        @(posedge clk); #1;
        check({"R2 ", tag}, {15'd0, cout, sum}, {15'd0, full});
        check({"R3 ", tag}, {31'd0, blk_p}, {31'd0, &(va | vb)});
        check({"R4 ", tag}, {31'd0, blk_g}, {31'd0, nocin[W]});
        check({"R5 ", tag}, {31'd0, cout}, {31'd0, nocin[W] | ((&(va | vb)) & vc)});
    endtask

    initial begin
        logic [W-1:0] lfsr_a, lfsr_b;
        a = 16'hBEEF; b = 16'h1234; cin = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 sum", {16'd0, sum}, 32'd0);
        check("R1 flags", {29'd0, cout, blk_g, blk_p}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R6: full propagate chain, no generates
        apply(16'hFFFF, 16'h0000, 1'b1, "R6 chain");
        check("R6 sum zero", {16'd0, sum}, 32'd0);
        check("R6 cout one", {31'd0, cout}, 32'd1);
        apply(16'hA5A5, 16'h5A5A, 1'b1, "R6 mixed");
        check("R6 mixed cout", {31'd0, cout}, 32'd1);

        // R7: carry from the top bit of each group into the next
        for (int k = 0; k < 3; k++) begin
            apply(16'h8 << (4*k), 16'h8 << (4*k), 1'b0, "R7 boundary");
            check("R7 next bit", {16'd0, sum}, {16'd0, 16'h10 << (4*k)});
        end

        // Every 4-bit pair at each group position, under three surrounding fills
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 3; f++) begin
                for (int v = 0; v < 512; v++) begin
                    logic [W-1:0] fa, fb, mask;
                    mask = ~(16'hF << (4*k));
                    fa = (f == 0) ? 16'h0000 : (f == 1) ? 16'hFFFF : 16'hC3A5;
                    fb = (f == 2) ? 16'h3C5A : 16'h0000;
                    apply((fa & mask) | (16'(v[3:0]) << (4*k)),
                          (fb & mask) | (16'(v[7:4]) << (4*k)), v[8], "R7 sweep");
                end
            end
        end

        // Pseudo-random operand pairs
        lfsr_a = 16'hACE1; lfsr_b = 16'h1D2B;
        for (int i = 0; i < 20000; i++) begin
            lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
            lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
            apply(lfsr_a, lfsr_b ^ 16'(i), lfsr_a[0] ^ lfsr_b[3], "R2 random");
        end

        // Extremes
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R4 max");
        apply(16'h0000, 16'h0000, 1'b0, "R3 zero");
        apply(16'h8000, 16'h8000, 1'b0, "R4 top");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(TCLK * 190000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule